// File: doc/BRIEF.md
# Function Unit with Status Flags

This combinational block is the arithmetic, logic and shift stage of a small datapath. It takes two operands and a 4-bit operation code, and on the same cycle returns the result together with four condition flags: overflow, carry, negative and zero. It holds no state, so a new operation may be presented on every cycle.

Inside, the operation code is split into three selects. An output-mux select steers between the shifter and the arithmetic/logic side. A 4-bit select picks the arithmetic or logic operation. A 2-bit select drives the shifter, which acts on the second operand only. The arithmetic side is a single ripple adder. Its second input is chosen from zero, B, the complement of B, or all ones, and it has a carry-in. This gives increment, decrement, add, subtract and two pass-through codes from one adder.

The downstream branch logic reads the negative and zero flags. The carry and overflow flags are meaningful only for arithmetic codes.

Top module: `fu_core`

## Requirements
- R1: Codes 0000 to 0111 are arithmetic: 0000 gives F=A, 0001 gives A+1, 0010 gives A+B, 0011 gives A+B+1, 0100 gives A+~B, 0101 gives A+~B+1, 0110 gives A-1 (formed as A plus all ones), and 0111 gives F=A (formed as A plus all ones plus one). All results wrap modulo 2^16.
- R2: For arithmetic codes, C is the carry out of bit 15 of the adder. For example, code 0110 sets C exactly when A is nonzero, and code 0111 always sets C.
- R3: For arithmetic codes, V is set when A and the adder's second input share a sign bit and the result's sign bit differs from it. This is the same as saying the signed sum leaves the 16-bit range.
- R4: Codes 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A.
- R5: Code 1100 passes B. Code 1101 shifts B right by one and code 1110 shifts B left by one. The vacated bit is filled with 0.
- R6: The unused code 1111 gives F=0.
- R7: For every code from 1000 to 1111, V and C are 0.
- R8: For every code, Z is 1 exactly when all 16 result bits are 0, and N equals result bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand, and the shifter input |
| fs_i | input | 4 | Operation code |
| f_o | output | 16 | Result |
| v_o | output | 1 | Signed overflow flag |
| c_o | output | 1 | Carry-out flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |

## Verification
Random operands almost never produce the flag corners. These include signed overflow on a decrement (A=8000h), overflow on a subtract of a positive value from the most negative number, and a zero result from a carry that wraps (increment of FFFFh, or A minus itself). Directed vectors aimed at those boundaries run first. A stream of pseudo-random operands then sweeps all sixteen codes in rotation. An independent signed-range model computes the expected overflow, so it is not derived from the sign-bit formula.

// File: rtl/fu_pkg.sv
package fu_pkg;

    localparam int FS_W = 4;
    localparam int G_W  = 4;
    localparam int H_W  = 2;

    // Sub-selects derived from the operation code
    typedef struct packed {
        logic           mf;   // 1: shifter drives the result
        logic [G_W-1:0] g;    // arithmetic / logic select
        logic [H_W-1:0] h;    // shifter select
    } fu_sel_t;

    // Shifter operations (h field)
    typedef enum logic [H_W-1:0] {
        SH_PASS  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_NONE  = 2'b11
    } fu_shop_t;

    // Logic operations (low two bits of g)
    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOT = 2'b11
    } fu_lgop_t;

endpackage

// File: rtl/fu_decode.sv
module fu_decode
    import fu_pkg::*;
(
    input  logic [FS_W-1:0] fs_i,
    output fu_sel_t         sel_o
);

    fu_sel_t sel_d;

    always_comb begin
        sel_d    = '0;
        sel_d.mf = fs_i[3] & fs_i[2];
        sel_d.g  = fs_i;
        sel_d.h  = fs_i[1:0];
    end

    assign sel_o = sel_d;

endmodule

// File: rtl/fu_arith.sv
module fu_arith #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       g_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] y_d;
    logic [WIDTH:0]   cy;

    // second adder input: 0, B, ~B or all ones
    always_comb begin
        unique case (g_i[2:1])
            2'b00:   y_d = '0;
            2'b01:   y_d = b_i;
            2'b10:   y_d = ~b_i;
            default: y_d = '1;
        endcase
    end

    assign cy[0] = g_i[0];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_o[i]  = a_i[i] ^ y_d[i] ^ cy[i];
        assign cy[i+1]   = (a_i[i] & y_d[i]) | (cy[i] & (a_i[i] ^ y_d[i]));
    end

    assign cout_o = cy[WIDTH];
    assign ovf_o  = (a_i[MSB] & y_d[MSB] & ~sum_o[MSB])
                  | (~a_i[MSB] & ~y_d[MSB] & sum_o[MSB]);

    // R2: adding zero with no carry-in never carries and passes A
    always_comb begin
        if (g_i == 3'b000) begin
            a_r2_no_carry_on_pass: assert (cout_o == 1'b0 && sum_o == a_i)
                else $error("pass-through produced a carry or changed A");
        end
    end

    // R3: overflow needs operands of equal sign
    always_comb begin
        if (a_i[MSB] != y_d[MSB]) begin
            a_r3_mixed_sign_no_ovf: assert (!ovf_o)
                else $error("overflow flagged for mixed-sign operands");
        end
    end

endmodule

// File: rtl/fu_logic.sv
module fu_logic
    import fu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] out_o
);

    always_comb begin
        unique case (fu_lgop_t'(op_i))
            LG_AND:  out_o = a_i & b_i;
            LG_OR:   out_o = a_i | b_i;
            LG_XOR:  out_o = a_i ^ b_i;
            default: out_o = ~a_i;
        endcase
    end

endmodule

// File: rtl/fu_shift.sv
module fu_shift
    import fu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic [H_W-1:0]   h_i,
    output logic [WIDTH-1:0] out_o
);

    always_comb begin
        unique case (fu_shop_t'(h_i))
            SH_PASS:  out_o = b_i;
            SH_RIGHT: out_o = {1'b0, b_i[WIDTH-1:1]};
            SH_LEFT:  out_o = {b_i[WIDTH-2:0], 1'b0};
            default:  out_o = '0;
        endcase
    end

endmodule

// File: rtl/fu_core.sv
module fu_core
    import fu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [FS_W-1:0]  fs_i,
    output logic [WIDTH-1:0] f_o,
    output logic             v_o,
    output logic             c_o,
    output logic             n_o,
    output logic             z_o
);

    typedef struct packed {
        logic [WIDTH-1:0] f;
        logic             v;
        logic             c;
        logic             n;
        logic             z;
    } fu_res_t;

    fu_sel_t          sel;
    logic [WIDTH-1:0] arith_f, logic_f, shift_f;
    logic             arith_c, arith_v;
    fu_res_t          res_d;

    fu_decode u_dec (
        .fs_i  (fs_i),
        .sel_o (sel)
    );

    fu_arith #(.WIDTH(WIDTH)) u_arith (
        .a_i    (a_i),
        .b_i    (b_i),
        .g_i    (sel.g[2:0]),
        .sum_o  (arith_f),
        .cout_o (arith_c),
        .ovf_o  (arith_v)
    );

    fu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (sel.g[1:0]),
        .out_o (logic_f)
    );

    fu_shift #(.WIDTH(WIDTH)) u_shift (
        .b_i   (b_i),
        .h_i   (sel.h),
        .out_o (shift_f)
    );

    always_comb begin
        res_d = '0;
        if (sel.mf) begin
            res_d.f = shift_f;
        end else if (sel.g[3]) begin
            res_d.f = logic_f;
        end else begin
            res_d.f = arith_f;
            res_d.c = arith_c;
            res_d.v = arith_v;
        end
        res_d.n = res_d.f[WIDTH-1];
        res_d.z = ~|res_d.f;
    end

    assign f_o = res_d.f;
    assign v_o = res_d.v;
    assign c_o = res_d.c;
    assign n_o = res_d.n;
    assign z_o = res_d.z;

    always_comb begin
        a_r1_pass_a: assert (!(fs_i == 4'b0000 || fs_i == 4'b0111) || f_o == a_i)
            else $error("pass code did not return A");
        a_r5_pass_b: assert (fs_i != 4'b1100 || f_o == b_i)
            else $error("shifter pass did not return B");
        a_r5_right_fill: assert (fs_i != 4'b1101 || f_o[WIDTH-1] == 1'b0)
            else $error("right shift did not fill with zero");
        a_r5_left_fill: assert (fs_i != 4'b1110 || f_o[0] == 1'b0)
            else $error("left shift did not fill with zero");
        a_r6_unused_zero: assert (fs_i != 4'b1111 || (f_o == '0 && z_o))
            else $error("unused code gave a nonzero result");
        a_r7_flags_clear: assert (!fs_i[3] || (!v_o && !c_o))
            else $error("V or C set for a non-arithmetic code");
        a_r4_not_a: assert (fs_i != 4'b1011 || f_o == ~a_i)
            else $error("complement code wrong");
    end

endmodule

// File: tb/sim_fu_core.sv
module sim_fu_core;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_i = '0, b_i = '0;
    logic [3:0]   fs_i = '0;
    logic [W-1:0] f_o;
    logic         v_o, c_o, n_o, z_o;

    always #2 clk = ~clk;

    fu_core #(.WIDTH(W)) u0 (
        .a_i(a_i), .b_i(b_i), .fs_i(fs_i),
        .f_o(f_o), .v_o(v_o), .c_o(c_o), .n_o(n_o), .z_o(z_o)
    );

    typedef struct {
        logic [W-1:0] a, b;
        logic [3:0]   fs;
        logic [W-1:0] f;
        logic         v, c, n, z;
    } item_t;

    item_t exp_q[$];
    int checks = 0;
    int errs   = 0;
    logic [31:0] seed = 32'h1F2E3D4C;

    function automatic item_t model(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] fs);
        item_t it;
        logic [W-1:0] y;
        logic         cin;
        logic [W:0]   s;
        int           sr;
        it.a = a; it.b = b; it.fs = fs;
        it.f = '0; it.v = 1'b0; it.c = 1'b0;
        if (fs < 4'd8) begin
            case (fs)
                4'd0: begin y = 16'h0000; cin = 0; end
                4'd1: begin y = 16'h0000; cin = 1; end
                4'd2: begin y = b;        cin = 0; end
                4'd3: begin y = b;        cin = 1; end
                4'd4: begin y = ~b;       cin = 0; end
                4'd5: begin y = ~b;       cin = 1; end
                4'd6: begin y = 16'hFFFF; cin = 0; end
                default: begin y = 16'hFFFF; cin = 1; end
            endcase
            s    = {1'b0, a} + {1'b0, y} + {16'd0, cin};
            it.f = s[W-1:0];
            it.c = s[W];
            sr   = int'($signed(a)) + int'($signed(y)) + int'(cin);
            it.v = (sr > 32767) || (sr < -32768);
        end else begin
            case (fs)
                4'd8:  it.f = a & b;
                4'd9:  it.f = a | b;
                4'd10: it.f = a ^ b;
                4'd11: it.f = ~a;
                4'd12: it.f = b;
                4'd13: it.f = b >> 1;
                4'd14: it.f = b << 1;
                default: it.f = '0;
            endcase
        end
        it.n = it.f[W-1];
        it.z = (it.f == '0);
        return it;
    endfunction

    function automatic string f_req(logic [3:0] fs);
        if (fs < 4'd8)  return "R1";
        if (fs < 4'd12) return "R4";
        if (fs < 4'd15) return "R5";
        return "R6";
    endfunction

    task automatic chk(string req, string what, item_t it, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s fs=%b a=%h b=%h actual=%h expected=%h",
                     req, what, it.fs, it.a, it.b, act, exp);
        end
    endtask

    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] fs);
        @(posedge clk);
        a_i  = a;
        b_i  = b;
        fs_i = fs;
        exp_q.push_back(model(a, b, fs));
    endtask

    function automatic logic [31:0] next_rand(logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    // monitor: compare away from the driving edge
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            chk(f_req(it.fs), "F", it, f_o, it.f);
            chk(it.fs[3] ? "R7" : "R2", "C", it, {15'd0, c_o}, {15'd0, it.c});
            chk(it.fs[3] ? "R7" : "R3", "V", it, {15'd0, v_o}, {15'd0, it.v});
            chk("R8", "N", it, {15'd0, n_o}, {15'd0, it.n});
            chk("R8", "Z", it, {15'd0, z_o}, {15'd0, it.z});
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        rst = 1'b0;
        // idle state after reset: all-zero inputs (R1, R8)
        drive(16'h0000, 16'h0000, 4'b0000);
        // R3 overflow corners
        drive(16'h7FFF, 16'h0001, 4'b0010);
        drive(16'h8000, 16'h0000, 4'b0110);
        drive(16'h8000, 16'h0001, 4'b0101);
        drive(16'h7FFF, 16'h8000, 4'b0101);
        drive(16'h8000, 16'h8000, 4'b0010);
        // R2 carry corners
        drive(16'hFFFF, 16'h0000, 4'b0001);
        drive(16'h0000, 16'h0000, 4'b0110);
        drive(16'h0005, 16'h0005, 4'b0101);
        drive(16'h1234, 16'h0000, 4'b0111);
        drive(16'h0003, 16'hFFFC, 4'b0011);
        drive(16'h0000, 16'hFFFF, 4'b0100);
        // R4 logic
        drive(16'hF0F0, 16'hFF00, 4'b1000);
        drive(16'hF0F0, 16'h0F00, 4'b1001);
        drive(16'hAAAA, 16'hAAAA, 4'b1010);
        drive(16'hFFFF, 16'h1234, 4'b1011);
        // R5 shifts with zero fill
        drive(16'h0000, 16'h8001, 4'b1100);
        drive(16'hFFFF, 16'h8001, 4'b1101);
        drive(16'hFFFF, 16'h8001, 4'b1110);
        drive(16'h0000, 16'hFFFF, 4'b1101);
        // R6 unused code
        drive(16'hFFFF, 16'hFFFF, 4'b1111);
        // sweep all codes with pseudo-random operands
        for (int i = 0; i < 320; i++) begin
            seed = next_rand(seed);
            drive(seed[31:16], seed[15:0] ^ seed[23:8], 4'(i % 16));
        end
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule